// File: doc/BRIEF.md
# Configuration Transport Bus Bridge

This block connects a host's 32-bit asynchronous shared bus to two configuration targets: a parallel FPGA configuration port and a byte-wide parallel flash. The same bus lines also carry ordinary memory-mapped register traffic. One mode line tells the bridge whether the bus currently carries register traffic, which the bridge ignores, or transport traffic. A target line steers transport traffic either to the configuration port or to the flash path.

The host moves one word per four-phase handshake. It puts a word on the data lines and raises the strobe. The bridge captures the word on the synchronized rising edge of the strobe and finishes the work for that word. It then raises the acknowledge, which stays high until the host drops the strobe.

On the configuration-port path, every word goes out whole as one beat of a valid/ready stream. Valid stays high, with data held stable, until the port accepts the beat. On the flash path, a frame is made of three parts in this order: a byte count word, a start address word, and then payload words. Each payload word is split into bytes, lowest byte first. Each byte becomes one request on a valid/ready style byte interface, and the flash address goes up by one after every accepted byte. On flash reads, the returned bytes are packed into a word that the host receives together with the acknowledge. If the mode or the target changes in the middle of a frame, the transfer is dropped and a sticky error flag is set.

Top module: `cfg_transport_bridge`

## Requirements
- R1: After reset, host_ack_o, err_o, cfg_valid_o, fl_we_o and fl_re_o are all 0.
- R2: While host_mode_i is 0 (register mode), strobes get no acknowledge and cause no activity on either target.
- R3: With host_mode_i = 1 and host_target_i = 0, each strobed word appears on cfg_data_o with cfg_valid_o. Valid and data are held until cfg_ready_i is 1, so a beat with s stall cycles is visible for s+1 cycles. The beat is accepted exactly once.
- R4: The acknowledge rises only after the word has been fully handled. It stays high while the strobe is high, a strobe that stays high does not start a second transfer, and the acknowledge falls after the strobe is released.
- R5: With host_target_i = 1, the first word of a frame is the byte count and the second word is the flash start address. Neither header word causes a flash access.
- R6: Write payload bytes go out lowest byte first (bits 7:0, then 15:8, and so on). The first byte goes to the start address, and the address goes up by one for each accepted byte.
- R7: The last payload word carries only the bytes that remain in the count. After the count is used up, the next word is taken as the count of a new frame.
- R8: When host_dir_i is 1 at the count word, the frame is a read. Each strobed payload word returns the next bytes in host_rdata_o, lowest byte first, valid while the acknowledge is high. Byte lanes beyond the remaining count read as 0.
- R9: If the mode line falls, or the target line changes, while a frame is active, the transfer is aborted and err_o is set. err_o stays set until reset, and the next word starts a new frame at its count word.
- R10: A flash byte request (fl_we_o or fl_re_o) holds its address and data until fl_ready_i is 1.
- R11: At most one of cfg_valid_o, fl_we_o and fl_re_o is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_data_i | input | 32 | Host write data, stable while the strobe is high |
| host_strobe_i | input | 1 | Asynchronous word strobe from the host |
| host_mode_i | input | 1 | 1 = transport mode, 0 = register mode |
| host_target_i | input | 1 | 1 = flash, 0 = configuration port |
| host_dir_i | input | 1 | Flash direction, sampled at the count word: 1 = read |
| host_ack_o | output | 1 | Word acknowledge |
| host_rdata_o | output | 32 | Packed flash read data |
| err_o | output | 1 | Sticky abort flag |
| cfg_data_o | output | 32 | Configuration port beat data |
| cfg_valid_o | output | 1 | Configuration port beat valid |
| cfg_ready_i | input | 1 | Configuration port ready |
| fl_addr_o | output | 24 | Flash byte address |
| fl_wdata_o | output | 8 | Flash write byte |
| fl_we_o | output | 1 | Flash write request |
| fl_re_o | output | 1 | Flash read request |
| fl_rdata_i | input | 8 | Flash read byte, taken when fl_re_o and fl_ready_i are both high |
| fl_ready_i | input | 1 | Flash accepts the current byte request |

## Verification
A wrong frame phase shows up at the ports on the very next word. If a header is mistaken for payload, the flash sees requests before the payload arrives. If the phase falls behind, the bytes land at the wrong addresses, which the bench catches by checking the flash model's contents right after each frame. A wrong byte counter or lane index shows up as a byte written twice, a byte missing, or a byte in the wrong lane; the count of flash accesses and the packed read word catch these within one frame. A fault in the abort path shows up a few cycles after the mode line falls, as err_o staying low. It also shows up as a new frame whose first word is not taken as a count.

// File: rtl/cfgtb_pkg.sv
package cfgtb_pkg;
  typedef enum logic [1:0] {
    WS_IDLE,
    WS_CFG,
    WS_FLASH,
    WS_ACK
  } word_state_e;

  typedef enum logic [1:0] {
    PH_COUNT,
    PH_ADDR,
    PH_DATA
  } frame_phase_e;
endpackage

// File: rtl/cfgtb_sync.sv
module cfgtb_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfgtb_cfg_push.sv
module cfgtb_cfg_push #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic [DATA_W-1:0] word,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        valid <= 1'b0;
      end else if (start) begin
        valid <= 1'b1;
        data  <= word;
      end else if (valid && ready) begin
        valid <= 1'b0;
        done  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgtb_flash_seq.sv
module cfgtb_flash_seq #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24,
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              start,
  input  logic              rd,
  input  logic [DATA_W-1:0] word,
  input  logic [LANE_W-1:0] nbytes,
  input  logic              ready,
  input  logic [7:0]        rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        wdata,
  output logic              we,
  output logic              re,
  output logic              done,
  output logic [DATA_W-1:0] rword
);
  localparam int LANES = DATA_W / 8;
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic              busy;
  logic              rd_q;
  logic [IDX_W-1:0]  idx;
  logic [LANE_W-1:0] left;
  logic [DATA_W-1:0] wq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      rd_q  <= 1'b0;
      idx   <= '0;
      left  <= '0;
      wq    <= '0;
      addr  <= '0;
      rword <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (load) begin
        addr <= load_addr;
      end else if (start) begin
        busy  <= 1'b1;
        rd_q  <= rd;
        idx   <= '0;
        left  <= nbytes;
        wq    <= word;
        rword <= '0;
      end else if (busy && ready) begin
        addr <= addr + 1'b1;
        if (rd_q) rword[{idx, 3'b000} +: 8] <= rdata;
        idx  <= idx + 1'b1;
        left <= left - 1'b1;
        if (left == LANE_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign we    = busy && !rd_q;
  assign re    = busy && rd_q;
  assign wdata = wq[{idx, 3'b000} +: 8];
endmodule

// File: rtl/cfg_transport_bridge.sv
module cfg_transport_bridge #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 24,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              host_strobe_i,
  input  logic              host_mode_i,
  input  logic              host_target_i,
  input  logic              host_dir_i,
  output logic              host_ack_o,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              err_o,
  output logic [DATA_W-1:0] cfg_data_o,
  output logic              cfg_valid_o,
  input  logic              cfg_ready_i,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  output logic              fl_we_o,
  output logic              fl_re_o,
  input  logic [7:0]        fl_rdata_i,
  input  logic              fl_ready_i
);
  import cfgtb_pkg::*;

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES + 1);

  logic [3:0] ctl_s;
  logic       stb_s, mode_s, tgt_s, dir_s, stb_q, stb_rise;

  cfgtb_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({host_strobe_i, host_mode_i, host_target_i, host_dir_i}),
    .q (ctl_s)
  );

  assign {stb_s, mode_s, tgt_s, dir_s} = ctl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_s;
  end

  assign stb_rise = stb_s && !stb_q;

  word_state_e       st;
  frame_phase_e      ph;
  logic              tgt_lk, dir_lk;
  logic [CNT_W-1:0]  rem;
  logic [LANE_W-1:0] nb_q, nb_next;
  logic              frame_active, abort, take;
  logic              cfg_start, fl_load, fl_start;
  logic              cfg_done, fl_done;
  logic              push_valid, eng_we, eng_re;
  logic [DATA_W-1:0] fl_rword;

  assign frame_active = (ph != PH_COUNT) || (st == WS_CFG) || (st == WS_FLASH);
  assign abort        = frame_active && (!mode_s || (tgt_s != tgt_lk));
  assign take         = (st == WS_IDLE) && stb_rise && mode_s && !abort;
  assign cfg_start    = take && (ph == PH_COUNT) && !tgt_s;
  assign fl_load      = take && (ph == PH_ADDR);
  assign fl_start     = take && (ph == PH_DATA);
  assign nb_next      = (rem >= CNT_W'(LANES)) ? LANE_W'(LANES) : rem[LANE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= WS_IDLE;
      ph           <= PH_COUNT;
      tgt_lk       <= 1'b0;
      dir_lk       <= 1'b0;
      rem          <= '0;
      nb_q         <= '0;
      host_rdata_o <= '0;
      err_o        <= 1'b0;
    end else if (abort) begin
      st    <= WS_IDLE;
      ph    <= PH_COUNT;
      err_o <= 1'b1;
    end else begin
      case (st)
        WS_IDLE: begin
          if (take) begin
            case (ph)
              PH_COUNT: begin
                tgt_lk <= tgt_s;
                if (!tgt_s) begin
                  st <= WS_CFG;
                end else begin
                  rem    <= host_data_i[CNT_W-1:0];
                  dir_lk <= dir_s;
                  ph     <= PH_ADDR;
                  st     <= WS_ACK;
                end
              end
              PH_ADDR: begin
                ph <= (rem == '0) ? PH_COUNT : PH_DATA;
                st <= WS_ACK;
              end
              default: begin
                nb_q <= nb_next;
                st   <= WS_FLASH;
              end
            endcase
          end
        end
        WS_CFG: if (cfg_done) st <= WS_ACK;
        WS_FLASH: begin
          if (fl_done) begin
            rem <= rem - CNT_W'(nb_q);
            if (rem == CNT_W'(nb_q)) ph <= PH_COUNT;
            if (dir_lk) host_rdata_o <= fl_rword;
            st <= WS_ACK;
          end
        end
        default: if (!stb_s) st <= WS_IDLE;
      endcase
    end
  end

  assign host_ack_o = (st == WS_ACK);

  cfgtb_cfg_push #(.DATA_W(DATA_W)) u_push (
    .clk   (clk),
    .rst_n (rst_n),
    .abort (abort),
    .start (cfg_start),
    .word  (host_data_i),
    .ready (cfg_ready_i),
    .valid (push_valid),
    .data  (cfg_data_o),
    .done  (cfg_done)
  );

  cfgtb_flash_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort),
    .load      (fl_load),
    .load_addr (host_data_i[ADDR_W-1:0]),
    .start     (fl_start),
    .rd        (dir_lk),
    .word      (host_data_i),
    .nbytes    (nb_next),
    .ready     (fl_ready_i),
    .rdata     (fl_rdata_i),
    .addr      (fl_addr_o),
    .wdata     (fl_wdata_o),
    .we        (eng_we),
    .re        (eng_re),
    .done      (fl_done),
    .rword     (fl_rword)
  );

  assign cfg_valid_o = push_valid && mode_s;
  assign fl_we_o     = eng_we && mode_s;
  assign fl_re_o     = eng_re && mode_s;
endmodule

// File: rtl/cfg_transport_bridge_chk.sv
module cfg_transport_bridge_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abort,
  input logic              stb_s,
  input logic              host_ack_o,
  input logic              err_o,
  input logic              cfg_valid_o,
  input logic              cfg_ready_i,
  input logic [DATA_W-1:0] cfg_data_o,
  input logic              fl_we_o,
  input logic              fl_re_o,
  input logic              fl_ready_i,
  input logic [ADDR_W-1:0] fl_addr_o,
  input logic [7:0]        fl_wdata_o
);
  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid_o && !cfg_ready_i) |=> (abort || (cfg_valid_o && $stable(cfg_data_o))));

  assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_ack_o) |-> (!$past(stb_s) || err_o));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((fl_we_o || fl_re_o) && fl_ready_i) |=> (fl_addr_o == ADDR_W'($past(fl_addr_o) + 1'b1)));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  assert_fl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((fl_we_o || fl_re_o) && !fl_ready_i) |=>
      (abort || ((fl_we_o || fl_re_o) && $stable(fl_addr_o) && $stable(fl_wdata_o))));

  assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_valid_o, fl_we_o, fl_re_o}));
endmodule

bind cfg_transport_bridge cfg_transport_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .abort       (abort),
  .stb_s       (stb_s),
  .host_ack_o  (host_ack_o),
  .err_o       (err_o),
  .cfg_valid_o (cfg_valid_o),
  .cfg_ready_i (cfg_ready_i),
  .cfg_data_o  (cfg_data_o),
  .fl_we_o     (fl_we_o),
  .fl_re_o     (fl_re_o),
  .fl_ready_i  (fl_ready_i),
  .fl_addr_o   (fl_addr_o),
  .fl_wdata_o  (fl_wdata_o)
);

// File: tb/cfg_transport_bridge_test.sv
module cfg_transport_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // each entry: {stall cycles, word}; expected beat equals the word, seen stall+1 cycles
  localparam logic [39:0] VECS [NVEC] = '{
    {8'd0, 32'h0123_4567}, {8'd3, 32'hDEAD_BEEF}, {8'd1, 32'h0000_0000},
    {8'd6, 32'hFFFF_FFFF}, {8'd2, 32'hA5A5_5A5A}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] host_data_i = '0;
  logic        host_strobe_i = 1'b0, host_mode_i = 1'b0, host_target_i = 1'b0, host_dir_i = 1'b0;
  logic        host_ack_o, err_o, cfg_valid_o, fl_we_o, fl_re_o;
  logic [31:0] host_rdata_o, cfg_data_o;
  logic        cfg_ready_i = 1'b1, fl_ready_i = 1'b1;
  logic [23:0] fl_addr_o;
  logic [7:0]  fl_wdata_o, fl_rdata_i;

  cfg_transport_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_data_i(host_data_i), .host_strobe_i(host_strobe_i),
    .host_mode_i(host_mode_i), .host_target_i(host_target_i), .host_dir_i(host_dir_i),
    .host_ack_o(host_ack_o), .host_rdata_o(host_rdata_o), .err_o(err_o),
    .cfg_data_o(cfg_data_o), .cfg_valid_o(cfg_valid_o), .cfg_ready_i(cfg_ready_i),
    .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o), .fl_we_o(fl_we_o), .fl_re_o(fl_re_o),
    .fl_rdata_i(fl_rdata_i), .fl_ready_i(fl_ready_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int cfg_stall = 0, cfg_count = 0, cfg_vcycles = 0, fl_ops = 0;
  logic [31:0] cfg_last = '0;
  bit fl_throttle = 1'b0;
  logic [7:0] mem [256];

  assign fl_rdata_i = mem[fl_addr_o[7:0]];

  always @(posedge clk) begin
    if (cfg_valid_o) begin
      cfg_vcycles++;
      if (cfg_ready_i) begin cfg_count++; cfg_last = cfg_data_o; end
    end
    if ((fl_we_o || fl_re_o) && fl_ready_i) begin
      fl_ops++;
      if (fl_we_o) mem[fl_addr_o[7:0]] <= fl_wdata_o;
    end
  end

  always @(negedge clk) begin
    if (cfg_valid_o && cfg_stall > 0) begin cfg_ready_i <= 1'b0; cfg_stall--; end
    else cfg_ready_i <= 1'b1;
    fl_ready_i <= fl_throttle ? ~fl_ready_i : 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_word(input logic [31:0] d, input int hold, output logic [31:0] rd, output bit got);
    host_data_i = d;
    @(negedge clk);
    host_strobe_i = 1'b1;
    got = 1'b0;
    for (int i = 0; i < 300 && !got; i++) begin
      @(negedge clk);
      if (host_ack_o) got = 1'b1;
    end
    rd = host_rdata_o;
    repeat (hold) @(negedge clk);
    host_strobe_i = 1'b0;
    for (int i = 0; i < 300 && host_ack_o; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    bit got, seen;
    int c0, ops0;
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!host_ack_o && !err_o && !cfg_valid_o && !fl_we_o && !fl_re_o, "R1 reset outputs", 
          {27'd0, host_ack_o, err_o, cfg_valid_o, fl_we_o, fl_re_o}, 32'd0);
    rst_n = 1'b1;
    settle();

    // R2: register mode strobes are ignored
    host_data_i = 32'h1111_2222; @(negedge clk); host_strobe_i = 1'b1; seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (host_ack_o || cfg_valid_o || fl_we_o || fl_re_o) seen = 1'b1;
    end
    host_strobe_i = 1'b0;
    settle();
    check(!seen && cfg_count == 0 && fl_ops == 0, "R2 register mode ignored", {31'd0, seen}, 32'd0);

    // R3/R4: vector table on the configuration port path
    host_mode_i = 1'b1; host_target_i = 1'b0;
    settle();
    for (int v = 0; v < NVEC; v++) begin
      c0 = cfg_count; cfg_vcycles = 0; cfg_stall = int'(VECS[v][39:32]);
      host_word(VECS[v][31:0], 4, rd, got);
      check(got, "R4 ack for word", {31'd0, got}, 32'd1);
      check(cfg_last == VECS[v][31:0], "R3 beat data", cfg_last, VECS[v][31:0]);
      check(cfg_count == c0 + 1, "R4 one beat per held strobe", cfg_count, c0 + 1);
      check(cfg_vcycles == int'(VECS[v][39:32]) + 1, "R3 valid held under stall",
            cfg_vcycles, VECS[v][39:32] + 1);
      check(!host_ack_o, "R4 ack released", {31'd0, host_ack_o}, 32'd0);
    end

    // R5/R6/R10: flash write frame, 6 bytes at 0x10, throttled ready
    host_target_i = 1'b1; host_dir_i = 1'b0; fl_throttle = 1'b1;
    settle();
    host_word(32'd6, 0, rd, got);
    host_word(32'h10, 0, rd, got);
    check(fl_ops == 0, "R5 header words make no flash access", fl_ops, 0);
    host_word(32'h4433_2211, 0, rd, got);
    host_word(32'h0000_6655, 0, rd, got);
    check({mem[8'h13], mem[8'h12], mem[8'h11], mem[8'h10]} == 32'h4433_2211, "R6 low-first bytes",
          {mem[8'h13], mem[8'h12], mem[8'h11], mem[8'h10]}, 32'h4433_2211);
    check({mem[8'h15], mem[8'h14]} == 16'h6655, "R10 bytes under back-pressure",
          {16'd0, mem[8'h15], mem[8'h14]}, 32'h6655);
    check(mem[8'h16] == 8'hEE && fl_ops == 6, "R7 only counted bytes written", fl_ops, 6);

    // R7: next word starts a fresh frame
    host_word(32'd1, 0, rd, got);
    host_word(32'h20, 0, rd, got);
    host_word(32'hAABB_CCDD, 0, rd, got);
    check(mem[8'h20] == 8'hDD && mem[8'h21] == 8'hEE, "R7 new frame after count reached",
          {16'd0, mem[8'h21], mem[8'h20]}, 32'h0000_EEDD);

    // R8: read frame of 5 bytes from 0x10
    host_dir_i = 1'b1;
    settle();
    ops0 = fl_ops;
    host_word(32'd5, 0, rd, got);
    host_word(32'h10, 0, rd, got);
    host_word(32'h0, 0, rd, got);
    check(rd == 32'h4433_2211, "R8 read word lanes", rd, 32'h4433_2211);
    host_word(32'h0, 0, rd, got);
    check(rd == 32'h0000_0055, "R8 partial read zero-filled", rd, 32'h0000_0055);
    check(fl_ops == ops0 + 5, "R8 read byte count", fl_ops, ops0 + 5);

    // R9: abort in mid-frame, then restart
    host_dir_i = 1'b0; fl_throttle = 1'b0;
    settle();
    check(!err_o, "R9 no error before abort", {31'd0, err_o}, 32'd0);
    host_word(32'd8, 0, rd, got);
    host_word(32'h30, 0, rd, got);
    host_word(32'h0403_0201, 0, rd, got);
    host_mode_i = 1'b0;
    repeat (10) @(negedge clk);
    check(err_o, "R9 error set on abort", {31'd0, err_o}, 32'd1);
    host_mode_i = 1'b1;
    settle();
    host_word(32'd2, 0, rd, got);
    host_word(32'h40, 0, rd, got);
    host_word(32'h0000_BEEF, 0, rd, got);
    check(mem[8'h40] == 8'hEF && mem[8'h41] == 8'hBE && mem[8'h42] == 8'hEE, "R9 restart at count",
          {8'd0, mem[8'h42], mem[8'h41], mem[8'h40]}, 32'h00EE_BEEF);
    check(mem[8'h33] == 8'h04 && mem[8'h34] == 8'hEE, "R9 aborted frame stopped",
          {16'd0, mem[8'h34], mem[8'h33]}, 32'h0000_EE04);
    check(err_o, "R9 error sticky", {31'd0, err_o}, 32'd1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule